// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This block divides a dividend that is twice as wide as the divisor and returns a single-width quotient and a single-width remainder. One width code picks the operand size for each operation: 8, 16 or 32 bits. The dividend is given as two halves, and each half holds one operand width. Operands are read as unsigned or as two's complement numbers, under the control of a mode input.

Work starts with a one-cycle start pulse. The divisor is checked for zero at once. If it is not zero, the unit runs a restoring shift-subtract loop on magnitudes and produces one quotient bit per clock, so it takes twice the operand width in iterations. It then applies signs and a range check. A quotient that does not fit the selected width raises an overflow error and is never wrapped. A single-cycle done pulse marks each result or error. The quotient, remainder and error flags then keep their values until the next operation finishes.

Top module: `div_wide_unit`

## Requirements
- R1: While reset is held, and right after it, `done`, `quotient`, `remainder`, `err_div0` and `err_ovf` are all 0.
- R2: `width_sel` 2'b00 selects N=8, 2'b01 selects N=16, and 2'b10 or 2'b11 selects N=32. The dividend is {`dvd_hi`[N-1:0], `dvd_lo`[N-1:0]} and the divisor is `divisor`[N-1:0]. Input bits above N are ignored. Results sit in bits N-1:0, and output bits above N are 0.
- R3: With `signed_mode`=0 the operands are unsigned. `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor.
- R4: With `signed_mode`=1 the operands are two's complement at their widths. The quotient is truncated toward zero and the remainder takes the sign of the dividend. For example, at N=8, -48/5 gives quotient 8'hF7 and remainder 8'hFD.
- R5: If the true quotient lies outside 0..2^N-1 (unsigned) or outside -2^(N-1)..2^(N-1)-1 (signed), the unit reports `err_ovf`=1 and returns `quotient`=0 and `remainder`=0.
- R6: A divisor that is zero in its N bits reports `err_div0`=1 with zero results, one cycle after the start is sampled. This error takes precedence, so the two error flags are never high together.
- R7: When the divisor is not zero, `done` rises 2N+1 clock edges after the edge that samples `start`.
- R8: `done` is high for exactly one cycle. Outputs and flags change only when `done` rises. Input changes with no start leave the outputs unchanged.
- R9: A `start` that arrives while an operation is in progress is ignored, and it yields no extra result.
- R10: On a result without an error, the magnitude of the remainder is smaller than the magnitude of the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken when idle) |
| signed_mode | input | 1 | 1 = two's complement operands |
| width_sel | input | 2 | Operand width code |
| dvd_hi | input | 32 | Upper half of the dividend |
| dvd_lo | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| quotient | output | 32 | Quotient, held until the next completion |
| remainder | output | 32 | Remainder, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| err_div0 | output | 1 | Divisor was zero |
| err_ovf | output | 1 | Quotient out of range for the width |

## Verification
Some properties are checked by assertions on every cycle. These are: done lasts a single cycle; outputs hold between completions; at most one error flag is set; error results read zero; the start input cannot reload the divisor while busy; and the remainder is below the divisor when the loop ends. The correct quotient and remainder values can only be shown by the bench's scenarios. These scenarios cover the signed rules for truncation and remainder sign, the signed and unsigned overflow boundaries (-128/1 passes, -128/-1 fails), a divisor whose only set bits lie above the width, and the exact latency for each width.

// File: rtl/div_pkg.sv
// Shared constants, types and helpers for the wide divider.
// Assumes the widest operand is XLEN bits; narrower widths are XLEN/4 and XLEN/2.
package div_pkg;
    localparam int XLEN = 32;
    localparam int DLEN = 2 * XLEN;
    localparam int CNTW = $clog2(DLEN + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } div_state_e;

    // Operand width in bits for a width code; codes above 1 mean full width.
    function automatic int unsigned wid_bits(input logic [1:0] code);
        case (code)
            2'b00:   return XLEN / 4;
            2'b01:   return XLEN / 2;
            default: return XLEN;
        endcase
    endfunction
endpackage

// File: rtl/div_operand_prep.sv
// Combinational operand conditioning: masks operands to the chosen width,
// finds operand signs, takes magnitudes, left-justifies the dividend and
// flags a zero divisor. Assumes signs only matter when signed_mode is set.
module div_operand_prep
    import div_pkg::*;
(
    input  logic            signed_mode,
    input  logic [1:0]      width_sel,
    input  logic [XLEN-1:0] dvd_hi,
    input  logic [XLEN-1:0] dvd_lo,
    input  logic [XLEN-1:0] dvs,
    output logic [DLEN-1:0] dvd_mag,
    output logic [XLEN-1:0] dvs_mag,
    output logic            dvd_neg,
    output logic            dvs_neg,
    output logic            dvs_zero,
    output logic [CNTW-1:0] iters
);
    int unsigned     n;
    logic [XLEN-1:0] lane_mask;
    logic [XLEN-1:0] sign_bit;
    logic [XLEN-1:0] dvs_raw;
    logic [XLEN-1:0] dvs_abs;
    logic [DLEN-1:0] pair_mask;
    logic [DLEN-1:0] dvd_raw;
    logic [DLEN-1:0] dvd_abs;

    // Build masked operands, magnitudes and the iteration count.
    always_comb begin
        n         = wid_bits(width_sel);
        lane_mask = {XLEN{1'b1}} >> (XLEN - n);
        sign_bit  = lane_mask & ~(lane_mask >> 1);
        pair_mask = {DLEN{1'b1}} >> (DLEN - 2 * n);
        dvd_raw   = ({{XLEN{1'b0}}, dvd_hi & lane_mask} << n)
                  | {{XLEN{1'b0}}, dvd_lo & lane_mask};
        dvs_raw   = dvs & lane_mask;
        dvd_neg   = signed_mode & (|(dvd_hi & sign_bit));
        dvs_neg   = signed_mode & (|(dvs & sign_bit));
        dvd_abs   = dvd_neg ? ((~dvd_raw + DLEN'(1)) & pair_mask) : dvd_raw;
        dvs_abs   = dvs_neg ? ((~dvs_raw + XLEN'(1)) & lane_mask) : dvs_raw;
        dvs_zero  = (dvs_raw == '0);
        dvd_mag   = dvd_abs << (DLEN - 2 * n);
        dvs_mag   = dvs_abs;
        iters     = CNTW'(2 * n);
    end
endmodule

// File: rtl/div_shift_core.sv
// Restoring shift-subtract engine on unsigned magnitudes. It takes operands
// when idle and start is high, runs one quotient bit per cycle for 'iters'
// cycles, then spends one cycle in FIN. A zero divisor skips straight to FIN.
// Assumes the dividend magnitude arrives left-justified.
module div_shift_core
    import div_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            signed_mode,
    input  logic [1:0]      width_sel,
    input  logic [DLEN-1:0] dvd_mag,
    input  logic [XLEN-1:0] dvs_mag,
    input  logic            dvd_neg,
    input  logic            dvs_neg,
    input  logic            dvs_zero,
    input  logic [CNTW-1:0] iters,
    output logic            fin,
    output logic [DLEN-1:0] qmag,
    output logic [XLEN-1:0] rmag,
    output logic            dvd_neg_q,
    output logic            dvs_neg_q,
    output logic            dz_q,
    output logic            signed_q,
    output logic [1:0]      width_q
);
    div_state_e      state_q;
    logic [CNTW-1:0] cnt_q;
    logic [DLEN-1:0] shreg_q;
    logic [XLEN-1:0] rem_q;
    logic [XLEN-1:0] dvsr_q;
    logic [XLEN:0]   trial;
    logic [XLEN-1:0] diff;
    logic            take;

    // One restoring step: bring in the next dividend bit and try a subtract.
    always_comb begin
        trial = {rem_q, shreg_q[DLEN-1]};
        diff  = trial[XLEN-1:0] - dvsr_q;
        take  = (trial >= {1'b0, dvsr_q});
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            shreg_q   <= '0;
            rem_q     <= '0;
            dvsr_q    <= '0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            dz_q      <= 1'b0;
            signed_q  <= 1'b0;
            width_q   <= 2'b00;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        shreg_q   <= dvd_mag;
                        rem_q     <= '0;
                        dvsr_q    <= dvs_mag;
                        cnt_q     <= iters;
                        dvd_neg_q <= dvd_neg;
                        dvs_neg_q <= dvs_neg;
                        dz_q      <= dvs_zero;
                        signed_q  <= signed_mode;
                        width_q   <= width_sel;
                        state_q   <= dvs_zero ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    shreg_q <= {shreg_q[DLEN-2:0], take};
                    rem_q   <= take ? diff : trial[XLEN-1:0];
                    cnt_q   <= cnt_q - CNTW'(1);
                    if (cnt_q == CNTW'(1)) begin
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fin  = (state_q == ST_FIN);
    assign qmag = shreg_q;
    assign rmag = rem_q;

    AST_RUN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));  // R7
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && start) |=> $stable(dvsr_q));  // R9
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_FIN) && !dz_q) |-> (rem_q < dvsr_q));  // R10
endmodule

// File: rtl/div_result_fix.sv
// Combinational result stage: applies signs to the magnitudes, checks that
// the quotient fits the width's range, and masks results to the width.
// Assumes qmag holds the full double-width magnitude quotient.
module div_result_fix
    import div_pkg::*;
(
    input  logic [DLEN-1:0] qmag,
    input  logic [XLEN-1:0] rmag,
    input  logic            dvd_neg,
    input  logic            dvs_neg,
    input  logic            signed_q,
    input  logic            dz,
    input  logic [1:0]      width_q,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem,
    output logic            ovf
);
    int unsigned     n;
    logic [XLEN-1:0] lane_mask;
    logic [DLEN-1:0] lim;
    logic [XLEN-1:0] qlow;
    logic [XLEN-1:0] qs;
    logic [XLEN-1:0] rs;
    logic            qneg;
    logic            range_bad;

    // Sign correction and range check for the finished quotient.
    always_comb begin
        n         = wid_bits(width_q);
        lane_mask = {XLEN{1'b1}} >> (XLEN - n);
        lim       = DLEN'(1) << (n - 1);
        qneg      = dvd_neg ^ dvs_neg;
        if (!signed_q) begin
            range_bad = (qmag > {{XLEN{1'b0}}, lane_mask});
        end else if (qneg) begin
            range_bad = (qmag > lim);
        end else begin
            range_bad = (qmag >= lim);
        end
        qlow = qmag[XLEN-1:0];
        qs   = qneg ? (~qlow + XLEN'(1)) : qlow;
        rs   = dvd_neg ? (~rmag + XLEN'(1)) : rmag;
        quo  = qs & lane_mask;
        rem  = rs & lane_mask;
        ovf  = range_bad & ~dz;
    end
endmodule

// File: rtl/div_wide_unit.sv
// Top of the double-width divider. Wires the operand stage, the iterative
// engine and the result stage, and registers the outputs, which change only
// on completion. Assumes start is a level sampled on each rising edge.
module div_wide_unit
    import div_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            signed_mode,
    input  logic [1:0]      width_sel,
    input  logic [XLEN-1:0] dvd_hi,
    input  logic [XLEN-1:0] dvd_lo,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quotient,
    output logic [XLEN-1:0] remainder,
    output logic            done,
    output logic            err_div0,
    output logic            err_ovf
);
    logic [DLEN-1:0] dvd_mag;
    logic [XLEN-1:0] dvs_mag;
    logic            dvd_neg, dvs_neg, dvs_zero;
    logic [CNTW-1:0] iters;
    logic            fin;
    logic [DLEN-1:0] qmag;
    logic [XLEN-1:0] rmag;
    logic            dvd_neg_q, dvs_neg_q, dz_q, signed_q;
    logic [1:0]      width_q;
    logic [XLEN-1:0] quo_fix, rem_fix;
    logic            ovf_fix;

    div_operand_prep u_prep (
        .signed_mode (signed_mode),
        .width_sel   (width_sel),
        .dvd_hi      (dvd_hi),
        .dvd_lo      (dvd_lo),
        .dvs         (divisor),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .dvd_neg     (dvd_neg),
        .dvs_neg     (dvs_neg),
        .dvs_zero    (dvs_zero),
        .iters       (iters)
    );

    div_shift_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .signed_mode (signed_mode),
        .width_sel   (width_sel),
        .dvd_mag     (dvd_mag),
        .dvs_mag     (dvs_mag),
        .dvd_neg     (dvd_neg),
        .dvs_neg     (dvs_neg),
        .dvs_zero    (dvs_zero),
        .iters       (iters),
        .fin         (fin),
        .qmag        (qmag),
        .rmag        (rmag),
        .dvd_neg_q   (dvd_neg_q),
        .dvs_neg_q   (dvs_neg_q),
        .dz_q        (dz_q),
        .signed_q    (signed_q),
        .width_q     (width_q)
    );

    div_result_fix u_fix (
        .qmag     (qmag),
        .rmag     (rmag),
        .dvd_neg  (dvd_neg_q),
        .dvs_neg  (dvs_neg_q),
        .signed_q (signed_q),
        .dz       (dz_q),
        .width_q  (width_q),
        .quo      (quo_fix),
        .rem      (rem_fix),
        .ovf      (ovf_fix)
    );

    // Output registers: capture result or error on the finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient  <= '0;
            remainder <= '0;
            done      <= 1'b0;
            err_div0  <= 1'b0;
            err_ovf   <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                err_div0  <= dz_q;
                err_ovf   <= ovf_fix;
                quotient  <= (dz_q || ovf_fix) ? '0 : quo_fix;
                remainder <= (dz_q || ovf_fix) ? '0 : rem_fix;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(err_ovf)));  // R8
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_div0, err_ovf}));  // R6
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_div0 || err_ovf) |-> ((quotient == '0) && (remainder == '0)));  // R5
endmodule

// File: tb/sim_div_wide_unit.sv
`timescale 1ns/1ps
module sim_div_wide_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        signed_mode;
    logic [1:0]  width_sel;
    logic [31:0] dvd_hi, dvd_lo, divisor;
    logic [31:0] quotient, remainder;
    logic        done, err_div0, err_ovf;

    typedef struct {
        logic [31:0] q;
        logic [31:0] r;
        logic        dz;
        logic        ov;
        logic        sm;
        int          n;
        int          lat;
        int          t0;
        logic [71:0] dmag;
    } exp_t;

    exp_t        expq[$];
    string       tagq[$];
    int          nchk = 0;
    int          nerr = 0;
    int          cyc = 0;
    logic [31:0] last_q, last_r;

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    div_wide_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .width_sel(width_sel), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .quotient(quotient), .remainder(remainder), .done(done),
        .err_div0(err_div0), .err_ovf(err_ovf)
    );

    task automatic chk(input string tag, input string what, input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic sm, input logic [1:0] w,
                                   input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] dv);
        exp_t e;
        int n;
        logic [71:0] m, ud, uv, uq, ur;
        logic signed [71:0] sd, sv, sq, sr, top, bot;
        n = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
        m = (72'd1 << n) - 72'd1;
        ud = (({40'd0, hi} & m) << n) | ({40'd0, lo} & m);
        uv = {40'd0, dv} & m;
        e.n = n; e.sm = sm; e.t0 = 0;
        e.dz = (uv == 72'd0); e.ov = 1'b0; e.q = '0; e.r = '0; e.dmag = uv;
        e.lat = e.dz ? 1 : 2 * n + 1;
        if (!e.dz) begin
            if (!sm) begin
                uq = ud / uv; ur = ud % uv;
                e.ov = (uq > m);
                e.q = uq[31:0]; e.r = ur[31:0];
            end else begin
                sd = $signed(ud << (72 - 2 * n)) >>> (72 - 2 * n);
                sv = $signed(uv << (72 - n)) >>> (72 - n);
                sq = sd / sv; sr = sd % sv;
                top = $signed((72'd1 << (n - 1)) - 72'd1);
                bot = -$signed(72'd1 << (n - 1));
                e.ov = (sq > top) || (sq < bot);
                e.dmag = (sv < 0) ? 72'(-sv) : 72'(sv);
                e.q = sq[31:0] & m[31:0]; e.r = sr[31:0] & m[31:0];
            end
            if (e.ov) begin e.q = '0; e.r = '0; end
        end
        return e;
    endfunction

    // Driver: launch one operation, queue its expectation, wait for it, check hold.
    task automatic run(input logic sm, input logic [1:0] w, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] dv, input string tag);
        exp_t e;
        e = model(sm, w, hi, lo, dv);
        @(negedge clk);
        start = 1'b1; signed_mode = sm; width_sel = w;
        dvd_hi = hi; dvd_lo = lo; divisor = dv;
        e.t0 = cyc;
        expq.push_back(e); tagq.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        wait (expq.size() == 0);
        @(negedge clk);
        dvd_hi = ~hi; dvd_lo = lo ^ 32'h5A5A5A5A; divisor = dv + 32'd3; signed_mode = ~sm;
        repeat (2) @(negedge clk);
        chk("R8", "done after pulse", 72'(done), 72'd0);
        chk("R8", "quotient held", 72'(quotient), 72'(last_q));
        chk("R8", "remainder held", 72'(remainder), 72'(last_r));
    endtask

    // Monitor: compare each completion with the oldest expectation.
    initial begin
        exp_t e;
        string tg;
        logic [71:0] rv, rabs;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && done === 1'b1) begin
                if (expq.size() == 0) begin
                    chk("R9", "unexpected done", 72'd1, 72'd0);
                end else begin
                    e = expq.pop_front(); tg = tagq.pop_front();
                    chk(tg, "quotient", 72'(quotient), 72'(e.q));
                    chk(tg, "remainder", 72'(remainder), 72'(e.r));
                    chk("R6", "err_div0", 72'(err_div0), 72'(e.dz));
                    chk("R5", "err_ovf", 72'(err_ovf), 72'(e.ov));
                    chk("R7", "latency", 72'(cyc - e.t0 - 1), 72'(e.lat));
                    if (!e.dz && !e.ov) begin
                        rv = {40'd0, remainder};
                        if (e.sm && (|((rv >> (e.n - 1)) & 72'd1)))
                            rabs = (72'd1 << e.n) - rv;
                        else
                            rabs = rv;
                        chk("R10", "remainder below divisor", 72'(rabs < e.dmag), 72'd1);
                    end
                    last_q = quotient; last_r = remainder;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; signed_mode = 1'b0; width_sel = 2'b00;
        dvd_hi = '0; dvd_lo = '0; divisor = '0;
        last_q = '0; last_r = '0;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", 72'(done), 72'd0);
        chk("R1", "quotient in reset", 72'(quotient), 72'd0);
        chk("R1", "remainder in reset", 72'(remainder), 72'd0);
        chk("R1", "flags in reset", 72'({err_div0, err_ovf}), 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after reset", 72'(done), 72'd0);

        // R3 unsigned at each width
        run(1'b0, 2'b00, 32'h01, 32'h2C, 32'h07, "R3");
        run(1'b0, 2'b00, 32'hFE, 32'hFF, 32'hFF, "R3");
        run(1'b0, 2'b01, 32'h0001, 32'h2345, 32'h1234, "R3");
        run(1'b0, 2'b10, 32'h00000123, 32'h456789AB, 32'h0F0F0F0F, "R3");
        // R2 bits above the width ignored; code 11 means 32 bits
        run(1'b0, 2'b00, 32'hABCD0012, 32'h7788FF34, 32'h55AA0033, "R2");
        run(1'b1, 2'b01, 32'h1234FFFF, 32'hCDEF8000, 32'hFFFF0007, "R2");
        run(1'b0, 2'b11, 32'h00000010, 32'h00000001, 32'h00000100, "R2");
        // R4 signed sign rules
        run(1'b1, 2'b00, 32'hFF, 32'hD0, 32'h05, "R4");
        run(1'b1, 2'b00, 32'h00, 32'h30, 32'hFB, "R4");
        run(1'b1, 2'b00, 32'hFF, 32'hD0, 32'hFB, "R4");
        run(1'b1, 2'b10, 32'hFFFFFFFF, 32'hFFFFFF00, 32'hFFFFFFF0, "R4");
        run(1'b1, 2'b00, 32'hFF, 32'h80, 32'h01, "R4");
        // R5 overflow boundaries
        run(1'b1, 2'b00, 32'hFF, 32'h80, 32'hFF, "R5");
        run(1'b1, 2'b00, 32'h00, 32'h80, 32'h01, "R5");
        run(1'b0, 2'b00, 32'h05, 32'h00, 32'h05, "R5");
        run(1'b0, 2'b01, 32'h0001, 32'h0000, 32'h0001, "R5");
        run(1'b0, 2'b01, 32'h0001, 32'h0000, 32'h0002, "R5");
        run(1'b1, 2'b10, 32'hFFFFFFFF, 32'h80000000, 32'hFFFFFFFF, "R5");
        run(1'b1, 2'b10, 32'h80000000, 32'h00000000, 32'h80000000, "R5");
        // R6 zero divisor, including bits set only above the width
        run(1'b0, 2'b01, 32'h0001, 32'h0000, 32'h00000000, "R6");
        run(1'b1, 2'b00, 32'h7F, 32'h00, 32'h00000100, "R6");

        // R9 start pulses while busy are ignored
        begin
            exp_t e;
            e = model(1'b0, 2'b00, 32'h00, 32'h64, 32'h0A);
            @(negedge clk);
            start = 1'b1; signed_mode = 1'b0; width_sel = 2'b00;
            dvd_hi = 32'h00; dvd_lo = 32'h64; divisor = 32'h0A;
            e.t0 = cyc;
            expq.push_back(e); tagq.push_back("R9");
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1; dvd_lo = 32'hC8; divisor = 32'h03;
            repeat (3) @(negedge clk);
            start = 1'b0;
            wait (expq.size() == 0);
            repeat (40) @(negedge clk);
            chk("R9", "no second result", 72'(quotient), 72'd10);
        end

        // Mixed operands across modes and widths
        for (int i = 0; i < 40; i++) begin
            logic        sm;
            logic [1:0]  w;
            logic [31:0] hi, lo, dv;
            sm = 1'($urandom & 1); w = 2'($urandom);
            hi = $urandom; lo = $urandom; dv = $urandom;
            if (i % 3 == 0) hi = hi & 32'h0000000F;
            run(sm, w, hi, lo, dv, sm ? "R4" : "R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule